// File: doc/BRIEF.md
# Dual-Rail Lookahead Magnitude Comparator

This block compares two unsigned operands whose bits arrive on two rails each: a true rail and a false rail. Each bit position forms a local relation: smaller, greater or equal. A binary tree of combining cells then merges neighbouring groups. The more significant group wins, so the logic depth grows with the logarithm of the operand width. The tree output becomes non-null as soon as the answer is logically fixed. If the operands differ at a high bit, the result is ready even while the lower bits are still null. An equal outcome needs every bit.

A synchronous result register captures the first non-null tree output. It drives three one-hot result wires and a completion flag. The register holds that word until every input rail has returned to zero, which is the null spacer. It then clears. A producer presents a data word, waits for `done`, returns all rails to zero, waits for `done` to fall, and only then presents the next word.

Top module: `drc_lookahead_cmp`

## Requirements
- R1: A bit with both rails at 0 is null. A bit with exactly one rail at 1 is valid, and the true rail means 1. Both rails at 1 is illegal on any input. While all inputs stay null, `done` stays 0.
- R2: Only one of `res_s`, `res_g`, `res_e` is ever 1. `res_s` means A<B, `res_g` means A>B and `res_e` means A=B.
- R3: Once both operands are fully valid, the captured result matches an unsigned integer comparison of A and B.
- R4: The most significant differing bit alone decides between smaller and greater, whatever the lower bits hold.
- R5: Suppose all bits from the MSB down to the first differing position are valid and every lower bit is null. The result and `done` are still asserted on the next clock edge.
- R6: `res_e` is asserted only after every bit of both operands is valid. An equal word with any null bit produces no result.
- R7: `done` is the OR of the three result wires. It rises on the first clock edge at which the tree output is non-null.
- R8: While `done` is 1 and any input rail is still 1, the result wires hold their value. On the first edge with all input rails at 0, the result wires and `done` clear.
- R9: A synchronous active-high `rst` clears the result wires and `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_t | input | WIDTH | Operand A, true rails |
| a_f | input | WIDTH | Operand A, false rails |
| b_t | input | WIDTH | Operand B, true rails |
| b_f | input | WIDTH | Operand B, false rails |
| res_s | output | 1 | Registered: A is smaller than B |
| res_g | output | 1 | Registered: A is greater than B |
| res_e | output | 1 | Registered: A equals B |
| done | output | 1 | Registered completion, OR of the result wires |

## Verification
The hardest condition to reach from the ports is early resolution. The tree must commit while the less significant bits are still null, and it must refuse to commit on an equal prefix that has holes. A producer that always presents whole words never shows either case. The bench therefore drives partial words through a per-bit validity mask. It makes only the upper bits valid down to the deciding position. It also builds an equal word with only the LSB missing, and later nulls part of a captured word to exercise the hold rule.

// File: rtl/drc_pkg.sv
package drc_pkg;
  // Relation encoding on three one-hot wires: bit 2 smaller, bit 1 greater, bit 0 equal.
  typedef logic [2:0] rel_t;
  localparam int REL_S = 2;
  localparam int REL_G = 1;
  localparam int REL_E = 0;
  localparam rel_t REL_NULL = 3'b000;
  localparam rel_t REL_EQ   = 3'b001;
endpackage

// File: rtl/drc_bit_cell.sv
module drc_bit_cell
  import drc_pkg::*;
(
  input  logic a_t,
  input  logic a_f,
  input  logic b_t,
  input  logic b_f,
  output rel_t rel
);
  // A relation appears only when both operand bits are valid.
  always_comb begin
    rel        = REL_NULL;
    rel[REL_S] = a_f & b_t;
    rel[REL_G] = a_t & b_f;
    rel[REL_E] = (a_t & b_t) | (a_f & b_f);
  end
endmodule

// File: rtl/drc_merge_cell.sv
module drc_merge_cell
  import drc_pkg::*;
(
  input  rel_t hi,
  input  rel_t lo,
  output rel_t rel
);
  // The upper group decides on its own. The lower group matters only when the upper group is equal.
  always_comb begin
    rel        = REL_NULL;
    rel[REL_S] = hi[REL_S] | (hi[REL_E] & lo[REL_S]);
    rel[REL_G] = hi[REL_G] | (hi[REL_E] & lo[REL_G]);
    rel[REL_E] = hi[REL_E] & lo[REL_E];
  end
endmodule

// File: rtl/drc_tree.sv
module drc_tree
  import drc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_t,
  input  logic [WIDTH-1:0] a_f,
  input  logic [WIDTH-1:0] b_t,
  input  logic [WIDTH-1:0] b_f,
  output rel_t             rel
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
  localparam int PADW   = 1 << LEVELS;
  localparam int PAD    = PADW - WIDTH;
  localparam int NODES  = 2 * PADW - 1;

  // Heap-ordered node store. Node k has its upper child at 2k+1 and its lower child at 2k+2.
  // Leaf j stands for padded position PADW-1-j, so leaves run from MSB to LSB.
  logic [NODES*3-1:0] nd;

  for (genvar j = 0; j < PADW; j++) begin : g_leaf
    localparam int POS = PADW - 1 - j;
    if (POS < PAD) begin : g_pad
      // Padding below the LSB counts as a valid equal bit.
      assign nd[(PADW-1+j)*3 +: 3] = REL_EQ;
    end else begin : g_bit
      drc_bit_cell u_bit (
        .a_t (a_t[POS-PAD]),
        .a_f (a_f[POS-PAD]),
        .b_t (b_t[POS-PAD]),
        .b_f (b_f[POS-PAD]),
        .rel (nd[(PADW-1+j)*3 +: 3])
      );
    end
  end

  for (genvar k = 0; k < PADW - 1; k++) begin : g_node
    drc_merge_cell u_merge (
      .hi  (nd[(2*k+1)*3 +: 3]),
      .lo  (nd[(2*k+2)*3 +: 3]),
      .rel (nd[k*3 +: 3])
    );
  end

  assign rel = nd[2:0];
endmodule

// File: rtl/drc_lookahead_cmp.sv
module drc_lookahead_cmp
  import drc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_t,
  input  logic [WIDTH-1:0] a_f,
  input  logic [WIDTH-1:0] b_t,
  input  logic [WIDTH-1:0] b_f,
  output logic             res_s,
  output logic             res_g,
  output logic             res_e,
  output logic             done
);
  rel_t tree_rel;
  rel_t res_q;
  logic all_null;
  logic all_valid;

  drc_tree #(.WIDTH(WIDTH)) u_tree (
    .a_t (a_t),
    .a_f (a_f),
    .b_t (b_t),
    .b_f (b_f),
    .rel (tree_rel)
  );

  assign all_null  = ~|(a_t | a_f | b_t | b_f);
  assign all_valid = &((a_t ^ a_f) & (b_t ^ b_f));

  // Capture the first non-null relation, then hold it until the spacer is complete.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= REL_NULL;
    end else if (res_q == REL_NULL) begin
      if (tree_rel != REL_NULL) res_q <= tree_rel;
    end else if (all_null) begin
      res_q <= REL_NULL;
    end
  end

  assign res_s = res_q[REL_S];
  assign res_g = res_q[REL_G];
  assign res_e = res_q[REL_E];
  assign done  = |res_q;

  a_r1_rails_legal: assert property (@(posedge clk) disable iff (rst)
    ((a_t & a_f) == '0) && ((b_t & b_f) == '0));

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_s, res_g, res_e}));

  a_r6_eq_complete: assert property (@(posedge clk) disable iff (rst)
    $rose(res_e) |-> $past(all_valid));

  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    (!done && tree_rel != REL_NULL) |=> done);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !all_null) |=> $stable({res_s, res_g, res_e}));

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (done && all_null) |=> !done);
endmodule

// File: tb/drc_lookahead_cmp_tb.sv
module drc_lookahead_cmp_tb_top;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
  logic res_s, res_g, res_e, done;
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  drc_lookahead_cmp #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .res_s(res_s), .res_g(res_g), .res_e(res_e), .done(done)
  );

  function automatic logic [2:0] exp_rel(input logic [W-1:0] a, input logic [W-1:0] b);
    if (a < b) return 3'b100;
    if (a > b) return 3'b010;
    return 3'b001;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] m);
    a_t = a & m; a_f = ~a & m;
    b_t = b & m; b_f = ~b & m;
  endtask

  function automatic logic [3:0] outs();
    return {res_s, res_g, res_e, done};
  endfunction

  // Full-word compare with spacer; checks latency, value, one-hot and clearing.
  task automatic t_compare(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [3:0] e;
    e = {exp_rel(a, b), 1'b1};
    drive(a, b, '1);
    @(negedge clk);
    chk(outs() == e, req, outs(), e);
    chk($countones({res_s, res_g, res_e}) == 1, "R2", outs(), e);
    drive('0, '0, '0);
    @(negedge clk);
    chk(outs() == 4'b0000, "R8 clear", outs(), 4'b0000);
  endtask

  task automatic t_null_idle();
    drive('0, '0, '0);
    repeat (3) @(negedge clk);
    chk(outs() == 4'b0000, "R1 idle null", outs(), 4'b0000);
  endtask

  // Valid only from the MSB down to position k; lower bits stay null.
  task automatic t_early(input int k, input bit a_big);
    logic [W-1:0] a, b, m;
    logic [3:0] e;
    a = 16'hA5C3; b = a;
    a[k] = a_big; b[k] = ~a_big;
    m = ~((16'd1 << k) - 16'd1);
    e = a_big ? 4'b0101 : 4'b1001;
    drive(a, b, m);
    @(negedge clk);
    chk(outs() == e, "R5 early resolve", outs(), e);
    drive('0, '0, '0);
    @(negedge clk);
    chk(outs() == 4'b0000, "R8 clear after early", outs(), 4'b0000);
  endtask

  task automatic t_eq_partial();
    drive(16'h3C3C, 16'h3C3C, 16'hFFFE);
    repeat (2) @(negedge clk);
    chk(outs() == 4'b0000, "R6 no eq with null lsb", outs(), 4'b0000);
    drive(16'h3C3C, 16'h3C3C, '1);
    @(negedge clk);
    chk(outs() == 4'b0011, "R6 eq after lsb", outs(), 4'b0011);
    drive('0, '0, '0);
    @(negedge clk);
  endtask

  task automatic t_hold();
    drive(16'h0010, 16'h0100, '1);
    @(negedge clk);
    chk(outs() == 4'b1001, "R3 smaller", outs(), 4'b1001);
    drive(16'h0010, 16'h0100, 16'h0001);
    @(negedge clk);
    chk(outs() == 4'b1001, "R8 hold partial null", outs(), 4'b1001);
    @(negedge clk);
    chk(outs() == 4'b1001, "R8 hold second cycle", outs(), 4'b1001);
    drive('0, '0, '0);
    @(negedge clk);
    chk(outs() == 4'b0000, "R8 clear after hold", outs(), 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(outs() == 4'b0000, "R9 reset", outs(), 4'b0000);
    rst = 1'b0;
    t_null_idle();
    t_compare(16'h8000, 16'h7FFF, "R4 msb priority");
    t_compare(16'h0001, 16'hFFFF, "R4 msb priority low");
    t_compare(16'h6E6E, 16'h6E6E, "R3 equal");
    t_compare(16'h0000, 16'h0000, "R3 zero equal");
    t_compare(16'hFFFF, 16'hFFFE, "R3 lsb differs");
    t_early(W-1, 1'b1);
    t_early(W-1, 1'b0);
    t_early(W/2, 1'b0);
    t_eq_partial();
    t_hold();
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      case (i % 3)
        0: b = a;
        1: b = a ^ (16'd1 << (W-1));
        default: b = W'($urandom);
      endcase
      t_compare(a, b, "R3 random");
    end
    // Reset while a result is held.
    drive(16'h1234, 16'h1233, '1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(outs() == 4'b0000, "R9 reset clears held", outs(), 4'b0000);
    rst = 1'b0;
    drive('0, '0, '0);
    @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule